// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns the refresh duties of an asynchronous DRAM controller. After reset it keeps the row and column strobes inactive for a start-up delay of at least 200 µs. It then runs a fixed number of warm-up refresh cycles back to back, without asking anyone for the bus. Only when the last warm-up cycle has finished does it raise `ready`, which releases the access controller that shares the strobes.

From then on it counts the refresh interval. All 1024 rows have to be refreshed within 16 ms, which gives one refresh about every 15.6 µs. Each interval that expires adds one refresh to a debt counter, and a non-zero debt raises `ref_req`. The access controller answers with `ref_gnt` when it can give up the bus. The access controller may hold the bus while refreshes pile up, up to a limit of eight. At that limit `ref_urgent` rises and the next refresh starts without a grant.

Each refresh is a column-before-row cycle. Both column strobes fall one set-up period before the row strobe and stay low while it is low. All strobes then rise together and remain high for a precharge period. The DRAM's internal row counter picks the row, so no address is driven. The data pins stay released, and the write and output enables are don't-care during the cycle. All counts are derived from the clock period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: For the first STARTUP cycles after reset release (20000 at the default 10 ns clock), `ras_n`, `lcas_n` and `ucas_n` stay high and `ready` stays low. The first column strobe fall comes at cycle STARTUP+1, and the first row strobe fall comes at cycle STARTUP+2.
- R2: Right after the start-up delay, exactly 8 refresh cycles run back to back whatever `ref_gnt` is. `ready` rises in the cycle after the eighth cycle's precharge ends (cycle STARTUP+104 by default) and never falls again before a reset.
- R3: In every refresh cycle both column strobes go low exactly one cycle before `ras_n` falls. They stay low for every cycle that `ras_n` is low, and they return high in the same cycle as `ras_n`.
- R4: `ras_n` stays low for exactly 6 cycles in every refresh cycle: the larger of the row-active time (60 ns) and the column hold after the row strobe falls, rounded up to whole cycles.
- R5: Between two refresh cycles, `ras_n` and both column strobes stay high for at least 5 cycles. That is the largest of the precharge time (40 ns), the remainder of the 104 ns cycle time, and the column-precharge delay. Back-to-back cycles fall 13 cycles apart.
- R6: Once `ready` is high, one refresh becomes due every INTERVAL cycles (1562 by default, from 16 ms / 1024 rows). With `ref_gnt` held high, `ras_n` falls 2 cycles after each interval ends, so the falls are exactly INTERVAL apart.
- R7: `ref_req` is high exactly when `ready` is high and the debt is non-zero. While the debt is below 8, no refresh starts without `ref_gnt`, and the debt never exceeds 8.
- R8: `ref_urgent` is high exactly when the debt equals 8. A refresh then starts in the next cycle regardless of `ref_gnt`, and the start lowers the debt to 7.
- R9: When `ref_gnt` rises with N refreshes postponed, N refresh cycles run back to back at 13-cycle spacing, and `ref_req` then falls.
- R10: `refresh_busy` is high in every cycle in which any strobe is driven low by the sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Access controller yields the strobes for a refresh |
| ready | output | 1 | Initialization complete, accesses allowed |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Debt limit reached, refresh forced |
| refresh_busy | output | 1 | Sequencer currently owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |

## Verification
The grant input is tried with four patterns, and the expected cycle of every row-strobe fall is predicted for each. Grant is held low through warm-up, which shows that warm-up ignores the grant. It is then held high, which shows the exact interval spacing. It is then held low long enough to hit the debt limit, which shows that the refresh is forced at the eighth postponed interval and not earlier. Finally it is released after a short postponement and after a saturated one, which shows that the owed refreshes drain back to back and no more. Each pulse is also measured for column lead, row-low width and simultaneous release, so a shortened or misordered waveform is told apart from a mistimed one.

// File: rtl/dram_ref_pkg.sv
// Package: shared state types and timing helpers for the refresh sequencer.
// Assumes all timing values are positive integers.
package dram_ref_pkg;

    typedef enum logic [1:0] {
        CBR_IDLE,
        CBR_LEAD,
        CBR_RASLO,
        CBR_PRE
    } cbr_state_e;

    // Whole cycles covering a duration in ns, never less than one.
    function automatic int cycles_for_ns(int dur_ns, int clk_ps);
        int c;
        c = (dur_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_startup_timer.sv
// Module: counts COUNT cycles after reset and then holds done high.
// Assumes COUNT >= 2.
module ref_startup_timer #(
    parameter int COUNT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(COUNT + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Count until the delay has elapsed, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(COUNT - 1)) begin
                done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/ref_interval_timer.sv
// Module: while enabled, pulses tick for one cycle every PERIOD cycles.
// Assumes PERIOD >= 2; the count restarts from zero when disabled.
module ref_interval_timer #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(PERIOD - 1));

    // Free-running interval count, independent of whether refreshes run.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ref_debt_counter.sv
// Module: saturating count of refreshes owed; inc adds one, dec removes one.
// Assumes dec is only raised while the count is non-zero.
module ref_debt_counter #(
    parameter int LIMIT = 8,
    localparam int DW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] debt,
    output logic          full
);
    logic [DW-1:0] debt_q;

    assign debt = debt_q;
    assign full = (debt_q == DW'(LIMIT));

    // Add and remove owed refreshes; a simultaneous pair cancels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10: if (!full) debt_q <= debt_q + 1'b1;
                2'b01: if (debt_q != '0) debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;
            endcase
        end
    end

endmodule

// File: rtl/ref_cbr_engine.sv
// Module: generates one column-before-row refresh waveform per start pulse.
// Phases: column lead, row low, precharge. Strobes are registered from the
// next state so they change only on clock edges. start is ignored while busy.
module ref_cbr_engine
    import dram_ref_pkg::*;
#(
    parameter int N_LEAD = 1,
    parameter int N_LOW  = 6,
    parameter int N_PRE  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAXN = max2(N_LEAD, max2(N_LOW, N_PRE));
    localparam int CW   = $clog2(MAXN + 1);

    cbr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ras_q, cas_q;

    // Next-state and phase-length counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        case (state_q)
            CBR_IDLE: begin
                if (start) begin
                    state_d = CBR_LEAD;
                    cnt_d   = CW'(N_LEAD - 1);
                end
            end
            CBR_LEAD: begin
                if (cnt_q == '0) begin
                    state_d = CBR_RASLO;
                    cnt_d   = CW'(N_LOW - 1);
                end
            end
            CBR_RASLO: begin
                if (cnt_q == '0) begin
                    state_d = CBR_PRE;
                    cnt_d   = CW'(N_PRE - 1);
                end
            end
            default: begin
                if (cnt_q == '0) begin
                    state_d = CBR_IDLE;
                end
            end
        endcase
    end

    // State, counter and glitch-free strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CBR_IDLE;
            cnt_q   <= '0;
            ras_q   <= 1'b1;
            cas_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ras_q   <= (state_d != CBR_RASLO);
            cas_q   <= !((state_d == CBR_LEAD) || (state_d == CBR_RASLO));
        end
    end

    assign busy  = (state_q != CBR_IDLE);
    assign done  = (state_q == CBR_PRE) && (cnt_q == '0);
    assign ras_n = ras_q;
    assign cas_n = cas_q;

endmodule

// File: rtl/dram_refresh_seq.sv
// Module: power-up and periodic refresh sequencer for an asynchronous DRAM.
// Waits the start-up delay, runs INIT_REFRESHES warm-up cycles, raises
// ready, then schedules one refresh per interval through a request/grant
// pair, forcing the cycle once DEBT_MAX refreshes are owed.
// Assumes the access controller leaves the strobes alone while
// refresh_busy is high and while ready is low.
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int CLK_PERIOD_PS  = 10000,
    parameter int STARTUP_NS     = 200000,
    parameter int REF_WINDOW_US  = 16000,
    parameter int ROWS           = 1024,
    parameter int INIT_REFRESHES = 8,
    parameter int DEBT_MAX       = 8,
    parameter int T_CSR_NS       = 5,
    parameter int T_CHR_NS       = 10,
    parameter int T_RAS_NS       = 60,
    parameter int T_RP_NS        = 40,
    parameter int T_RC_NS        = 104,
    parameter int T_RPC_NS       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ready,
    output logic ref_req,
    output logic ref_urgent,
    output logic refresh_busy,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n
);
    localparam int STARTUP_CYC = cycles_for_ns(STARTUP_NS, CLK_PERIOD_PS);
    localparam int INTERVAL_NS = (REF_WINDOW_US * 1000) / ROWS;
    localparam int INTERVAL_CYC = (INTERVAL_NS * 1000) / CLK_PERIOD_PS;
    localparam int N_LEAD = cycles_for_ns(T_CSR_NS, CLK_PERIOD_PS);
    localparam int N_LOW  = max2(cycles_for_ns(T_RAS_NS, CLK_PERIOD_PS),
                                 cycles_for_ns(T_CHR_NS, CLK_PERIOD_PS));
    localparam int N_PRE  = max2(cycles_for_ns(T_RP_NS, CLK_PERIOD_PS),
                            max2(cycles_for_ns(T_RC_NS, CLK_PERIOD_PS) - N_LOW,
                                 cycles_for_ns(T_RPC_NS, CLK_PERIOD_PS)));
    localparam int IW = $clog2(INIT_REFRESHES + 1);
    localparam int DW = $clog2(DEBT_MAX + 1);

    logic          boot_done;
    logic          tick;
    logic          eng_start, eng_busy, eng_done, cas_w;
    logic [DW-1:0] debt_w;
    logic          debt_full;
    logic          ready_q;
    logic [IW-1:0] init_cnt_q;

    ref_startup_timer #(.COUNT(STARTUP_CYC)) boot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (boot_done)
    );

    ref_interval_timer #(.PERIOD(INTERVAL_CYC)) ival_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready_q),
        .tick  (tick)
    );

    ref_debt_counter #(.LIMIT(DEBT_MAX)) debt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (eng_start && ready_q),
        .debt  (debt_w),
        .full  (debt_full)
    );

    ref_cbr_engine #(.N_LEAD(N_LEAD), .N_LOW(N_LOW), .N_PRE(N_PRE)) cbr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .busy  (eng_busy),
        .done  (eng_done),
        .ras_n (ras_n),
        .cas_n (cas_w)
    );

    // Start policy: warm-up ignores the grant; normal refresh needs it or a full debt.
    always_comb begin
        if (!ready_q) begin
            eng_start = boot_done && !eng_busy && (init_cnt_q != IW'(INIT_REFRESHES));
        end else begin
            eng_start = !eng_busy && (debt_w != '0) && (ref_gnt || debt_full);
        end
    end

    // Warm-up cycle count and the sticky ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_cnt_q <= '0;
            ready_q    <= 1'b0;
        end else if (!ready_q && eng_done) begin
            init_cnt_q <= init_cnt_q + 1'b1;
            if (init_cnt_q == IW'(INIT_REFRESHES - 1)) begin
                ready_q <= 1'b1;
            end
        end
    end

    assign ready        = ready_q;
    assign ref_req      = ready_q && (debt_w != '0);
    assign ref_urgent   = ready_q && debt_full;
    assign refresh_busy = eng_busy;
    assign lcas_n       = cas_w;
    assign ucas_n       = cas_w;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
// Module: protocol checker for the refresh sequencer, bound to the top.
// Measures strobe pulse widths and the start-up window with its own counters.
module dram_refresh_seq_chk #(
    parameter int STARTUP_CYC = 20000,
    parameter int N_LOW       = 6,
    parameter int N_PRE       = 5,
    parameter int DEBT_MAX    = 8,
    parameter int DW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          ref_urgent,
    input logic          refresh_busy,
    input logic          ras_n,
    input logic          lcas_n,
    input logic          ucas_n,
    input logic [DW-1:0] debt
);
    logic [15:0] low_cnt, high_cnt;
    logic [31:0] boot_cnt;

    // Lengths of the current row-low and row-high stretches, and time since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '1;
            boot_cnt <= '0;
        end else begin
            if (boot_cnt < 32'(STARTUP_CYC)) boot_cnt <= boot_cnt + 1;
            if (!ras_n) begin
                high_cnt <= '0;
                if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
                if (high_cnt != '1) high_cnt <= high_cnt + 1'b1;
            end
        end
    end

    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt < 32'(STARTUP_CYC)) |-> (ras_n && lcas_n && ucas_n && !ready)); // R1

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> ready); // R2

    AST_CAS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(!lcas_n) && $past(!ucas_n))); // R3

    AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (!lcas_n && !ucas_n)); // R3

    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt >= 16'(N_LOW))); // R4

    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcas_n) |-> (high_cnt >= 16'(N_PRE))); // R5

    AST_DEBT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(DEBT_MAX)); // R7

    AST_URGENT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent && !refresh_busy) |=> !lcas_n); // R8

    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcas_n || !ras_n) |-> refresh_busy); // R10

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .STARTUP_CYC (STARTUP_CYC),
    .N_LOW       (N_LOW),
    .N_PRE       (N_PRE),
    .DEBT_MAX    (DEBT_MAX),
    .DW          (DW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready        (ready),
    .ref_urgent   (ref_urgent),
    .refresh_busy (refresh_busy),
    .ras_n        (ras_n),
    .lcas_n       (lcas_n),
    .ucas_n       (ucas_n),
    .debt         (debt_w)
);

// File: tb/dram_refresh_seq_tb_top.sv
// Bench: scoreboard of predicted row-strobe fall cycles plus pulse-shape checks.
module dram_refresh_seq_tb_top;

    // Expected timing derived from the requirements at a 10 ns clock.
    localparam int S_CYC   = 200000 / 10;            // R1 start-up cycles
    localparam int INT_CYC = 16000000 / 1024 / 10;   // R6 interval cycles
    localparam int SPACING = 1 + 6 + 5 + 1;          // R5 back-to-back fall spacing
    localparam int READY_C = S_CYC + 2 + SPACING * 7 + 11; // R2

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ready, ref_req, ref_urgent, refresh_busy, ras_n, lcas_n, ucas_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    dram_refresh_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_gnt      (ref_gnt),
        .ready        (ready),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .refresh_busy (refresh_busy),
        .ras_n        (ras_n),
        .lcas_n       (lcas_n),
        .ucas_n       (ucas_n)
    );

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Driver side of the scoreboard: queue a predicted row-strobe fall.
    task automatic expect_fall(input int c);
        exp_q.push_back(c);
    endtask

    // Advance to the negative edge following clock edge number n.
    task automatic wait_cyc(input int n);
        do @(negedge clk); while (cyc < n);
    endtask

    function automatic int tk(input int m);
        return READY_C + m * INT_CYC;
    endfunction

    // Monitor: pops predictions on each fall and measures pulse shape.
    bit prev_ras = 1'b1;
    int low_len = 0;
    int lead_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R6", cyc, e);
                end
                chk(lead_len == 1, "R3", lead_len, 1);
                chk(refresh_busy == 1'b1, "R10", int'(refresh_busy), 1);
                low_len = 1;
            end else if (!ras_n) begin
                low_len++;
                chk(!lcas_n && !ucas_n, "R3", int'(lcas_n), 0);
            end else if (!prev_ras && ras_n) begin
                chk(low_len == 6, "R4", low_len, 6);
                chk(lcas_n && ucas_n, "R3", int'(lcas_n), 1);
            end
            if (ras_n && !lcas_n) lead_len++;
            else if (ras_n) lead_len = 0;
            prev_ras = ras_n;
        end
    end

    initial begin
        // R2 warm-up falls, R6 steady falls, R8 forced, R9 drains
        for (int i = 0; i < 8; i++) expect_fall(S_CYC + 2 + SPACING * i);
        for (int m = 1; m <= 3; m++) expect_fall(tk(m) + 2);
        expect_fall(tk(11) + 2);
        expect_fall(tk(12) + 2);
        for (int i = 0; i < 7; i++) expect_fall(tk(12) + 22 + SPACING * i);
        for (int i = 0; i < 3; i++) expect_fall(tk(15) + 22 + SPACING * i);
        expect_fall(tk(16) + 2);

        repeat (3) @(negedge clk);
        chk(ras_n && lcas_n && ucas_n, "R1", int'(ras_n), 1);
        chk(!ready && !ref_req, "R1", int'(ready), 0);
        rst_n = 1'b1;

        wait_cyc(S_CYC);
        chk(ras_n && lcas_n, "R1", int'(lcas_n), 1);
        wait_cyc(S_CYC + 1);
        chk(!lcas_n && ras_n, "R1", int'(lcas_n), 0);

        wait_cyc(READY_C - 1);
        chk(ready == 1'b0, "R2", int'(ready), 0);
        wait_cyc(READY_C);
        chk(ready == 1'b1, "R2", int'(ready), 1);
        chk(ref_req == 1'b0, "R7", int'(ref_req), 0);
        ref_gnt = 1'b1;

        wait_cyc(tk(3) + 20);
        chk(ref_req == 1'b0, "R7", int'(ref_req), 0);
        ref_gnt = 1'b0;

        wait_cyc(tk(10) + 5);
        chk(ref_req == 1'b1 && ref_urgent == 1'b0, "R7", int'(ref_urgent), 0);
        wait_cyc(tk(11));
        chk(ref_urgent == 1'b1, "R8", int'(ref_urgent), 1);
        wait_cyc(tk(11) + 1);
        chk(ref_urgent == 1'b0, "R8", int'(ref_urgent), 0);

        wait_cyc(tk(12) + 20);
        ref_gnt = 1'b1;
        wait_cyc(tk(12) + 200);
        chk(ref_req == 1'b0, "R9", int'(ref_req), 0);
        ref_gnt = 1'b0;

        wait_cyc(tk(13) + 5);
        chk(ref_req == 1'b1 && ras_n == 1'b1, "R7", int'(ras_n), 1);
        wait_cyc(tk(15) + 20);
        chk(ref_req == 1'b1, "R9", int'(ref_req), 1);
        ref_gnt = 1'b1;

        wait_cyc(tk(16) + 30);
        chk(ready == 1'b1, "R2", int'(ready), 1);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog at cycle %0d: actual=%0d expected=%0d", cyc, 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule